// File: doc/BRIEF.md
# Condition-Code Branch Resolution Unit

This block keeps the sign flags of a 16-bit load/store processor and resolves its conditional branches. Every value placed on the register-write bus is classified as negative, zero or positive, and a one-hot three-bit flag register records that class. Each new write replaces the previous class.

When an instruction word is presented with the already-incremented program counter, the unit decodes the branch opcode. It compares the three request bits of the instruction with the flags and returns the next program counter together with a taken indication. One mask mechanism covers all branches. Mask 111 always branches, mask 000 never branches, and the six other masks each select one sign relation. The branch target is the incremented PC plus the sign-extended 9-bit offset. The sum wraps modulo 2^16.

Top module: `cond_branch_unit`

## Requirements
- R1: After reset the flag output `cc_o` (bit 2 = negative, bit 1 = zero, bit 0 = positive) reads 3'b010.
- R2: When `wr_valid_i` is high at a clock edge, `cc_o` after that edge shows the class of `wr_data_i`. The class is 3'b100 if bit 15 is set, 3'b010 if the value is 0, and 3'b001 otherwise.
- R3: Without a write, `cc_o` keeps its value, and at all times exactly one bit of `cc_o` is set.
- R4: An instruction is a branch only when `eval_valid_i` is high and `instr_i[15:12]` equals 4'b0000. For any other instruction, `is_branch_o` and `taken_o` are low and `next_pc_o` equals `pc_i`.
- R5: A branch is taken when any of these holds: `instr_i[11]` is set with the negative flag set, `instr_i[10]` is set with the zero flag set, or `instr_i[9]` is set with the positive flag set.
- R6: A branch with `instr_i[11:9]` = 3'b111 is taken under every flag state. A branch with 3'b000 is never taken.
- R7: When the branch is taken, `next_pc_o` = `pc_i` + sign-extended `instr_i[8:0]`, modulo 2^16. When it is not taken, `next_pc_o` = `pc_i`. The outputs are combinational from the current inputs and flags.
- R8: A branch evaluated in the same cycle as a register write uses the flags from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Register-write bus strobe |
| wr_data_i | input | 16 | Value being written to the register file |
| eval_valid_i | input | 1 | Instruction word is to be evaluated this cycle |
| instr_i | input | 16 | Fetched instruction word |
| pc_i | input | 16 | Incremented program counter (branch address + 1) |
| cc_o | output | 3 | One-hot flags {negative, zero, positive} |
| is_branch_o | output | 1 | Instruction decoded as a branch |
| taken_o | output | 1 | Branch condition met |
| next_pc_o | output | 16 | Next program counter |

## Verification
The bench runs all eight masks against each of the three flag states. A design that ANDs the mask bits together, or compares the mask for equality with the flags, fails for the multi-bit masks. A design that special-cases 000 or 111 wrongly also fails here. Offsets of +255, -256 and 0 are applied at PCs near both ends of the address space, which exposes a zero-extended offset or a sum that saturates instead of wrapping. A write and a branch are issued together in one cycle to catch a design that passes the new flags straight through to the branch decision. Bit-15 values and a zero value catch a sign classifier that treats 0 as positive or reads the wrong bit.

// File: rtl/cb_pkg.sv
package cb_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned OP_W   = 4;
    localparam int unsigned OFF_W  = 9;

    typedef struct packed {
        logic neg;
        logic zer;
        logic pos;
    } ccode_t;

    localparam ccode_t CC_RESET = '{neg: 1'b0, zer: 1'b1, pos: 1'b0};

    function automatic ccode_t classify(input logic [DATA_W-1:0] v);
        ccode_t c;
        c.neg = v[DATA_W-1];
        c.zer = (v == '0);
        c.pos = !v[DATA_W-1] && (v != '0);
        return c;
    endfunction
endpackage

// File: rtl/cb_flag_reg.sv
module cb_flag_reg
    import cb_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid_i,
    input  logic [W-1:0] wr_data_i,
    output ccode_t       cc_o
);
    typedef struct packed {
        ccode_t cc;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_valid_i) begin
            st_d.cc.neg = wr_data_i[W-1];
            st_d.cc.zer = (wr_data_i == '0);
            st_d.cc.pos = !wr_data_i[W-1] && (wr_data_i != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cc: CC_RESET};
        else        st_q <= st_d;
    end

    assign cc_o = st_q.cc;
endmodule

// File: rtl/cb_br_decode.sv
module cb_br_decode
    import cb_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned OPW   = OP_W,
    parameter int unsigned OFFW  = OFF_W,
    parameter logic [OPW-1:0] BR_OP = '0
) (
    input  logic         eval_valid_i,
    input  logic [W-1:0] instr_i,
    output logic         is_branch_o,
    output ccode_t       mask_o,
    output logic [W-1:0] offset_o
);
    localparam int unsigned OP_LSB = W - OPW;
    localparam int unsigned EXT_W  = W - OFFW;

    logic [OFFW-1:0] off_raw;

    assign is_branch_o = eval_valid_i && (instr_i[W-1:OP_LSB] == BR_OP);
    assign mask_o      = '{neg: instr_i[OP_LSB-1],
                           zer: instr_i[OP_LSB-2],
                           pos: instr_i[OP_LSB-3]};
    assign off_raw     = instr_i[OFFW-1:0];

    generate
        if (EXT_W > 0) begin : g_sext
            assign offset_o = {{EXT_W{off_raw[OFFW-1]}}, off_raw};
        end else begin : g_trunc
            assign offset_o = off_raw[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/cb_br_target.sv
module cb_br_target
    import cb_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] offset_i,
    input  logic         take_i,
    output logic [W-1:0] next_pc_o
);
    logic [W-1:0] sum;

    assign sum       = pc_i + offset_i;
    assign next_pc_o = take_i ? sum : pc_i;
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
    import cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              eval_valid_i,
    input  logic [DATA_W-1:0] instr_i,
    input  logic [DATA_W-1:0] pc_i,
    output logic [2:0]        cc_o,
    output logic              is_branch_o,
    output logic              taken_o,
    output logic [DATA_W-1:0] next_pc_o
);
    ccode_t            cc_q;
    ccode_t            mask;
    logic              is_br;
    logic [DATA_W-1:0] offset;

    typedef struct packed {
        logic take;
    } res_t;

    res_t res_d;

    cb_flag_reg #(.W(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid_i),
        .wr_data_i  (wr_data_i),
        .cc_o       (cc_q)
    );

    cb_br_decode #(.W(DATA_W), .OPW(OP_W), .OFFW(OFF_W), .BR_OP('0)) u_dec (
        .eval_valid_i (eval_valid_i),
        .instr_i      (instr_i),
        .is_branch_o  (is_br),
        .mask_o       (mask),
        .offset_o     (offset)
    );

    always_comb begin
        res_d.take = is_br && ((mask.neg && cc_q.neg) ||
                               (mask.zer && cc_q.zer) ||
                               (mask.pos && cc_q.pos));
    end

    cb_br_target #(.W(DATA_W)) u_tgt (
        .pc_i      (pc_i),
        .offset_i  (offset),
        .take_i    (res_d.take),
        .next_pc_o (next_pc_o)
    );

    assign cc_o        = cc_q;
    assign is_branch_o = is_br;
    assign taken_o     = res_d.take;
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid_i,
    input logic [15:0] wr_data_i,
    input logic        eval_valid_i,
    input logic [15:0] instr_i,
    input logic [15:0] pc_i,
    input logic [2:0]  cc_o,
    input logic        is_branch_o,
    input logic        taken_o,
    input logic [15:0] next_pc_o
);
    a_r3_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc_o) == 1);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) && !$past(wr_valid_i) |-> $stable(cc_o));

    a_r2_neg: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i && wr_data_i[15] |=> cc_o == 3'b100);

    a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i && wr_data_i == 16'h0 |=> cc_o == 3'b010);

    a_r4_not_branch: assert property (@(posedge clk) disable iff (!rst_n)
        !is_branch_o |-> !taken_o && next_pc_o == pc_i);

    a_r4_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        is_branch_o |-> eval_valid_i && instr_i[15:12] == 4'h0);

    a_r6_always: assert property (@(posedge clk) disable iff (!rst_n)
        is_branch_o && instr_i[11:9] == 3'b111 |-> taken_o);

    a_r6_never: assert property (@(posedge clk) disable iff (!rst_n)
        instr_i[11:9] == 3'b000 |-> !taken_o);

    a_r7_target: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> next_pc_o == pc_i + {{7{instr_i[8]}}, instr_i[8:0]});
endmodule

bind cond_branch_unit cond_branch_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid_i   (wr_valid_i),
    .wr_data_i    (wr_data_i),
    .eval_valid_i (eval_valid_i),
    .instr_i      (instr_i),
    .pc_i         (pc_i),
    .cc_o         (cc_o),
    .is_branch_o  (is_branch_o),
    .taken_o      (taken_o),
    .next_pc_o    (next_pc_o)
);

// File: tb/cond_branch_unit_tb_top.sv
module cond_branch_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        eval_valid_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [15:0] pc_i = '0;
    logic [2:0]  cc_o;
    logic        is_branch_o;
    logic        taken_o;
    logic [15:0] next_pc_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int model_cc = 1;      // 0 = negative, 1 = zero, 2 = positive
    bit done = 0;

    cond_branch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
        .eval_valid_i(eval_valid_i), .instr_i(instr_i), .pc_i(pc_i),
        .cc_o(cc_o), .is_branch_o(is_branch_o), .taken_o(taken_o), .next_pc_o(next_pc_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles++;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int cc_bits(input int c);
        return (c == 0) ? 4 : (c == 1) ? 2 : 1;
    endfunction

    // One cycle: drive at negedge, compare before posedge, update model at posedge.
    task automatic step(input string tag, input bit wv, input logic [15:0] wd,
                        input bit ev, input logic [15:0] ins, input logic [15:0] pc);
        bit br, tk;
        int off, exp_pc;
        @(negedge clk);
        wr_valid_i = wv; wr_data_i = wd; eval_valid_i = ev; instr_i = ins; pc_i = pc;
        #1;
        br = ev && (ins[15:12] == 4'h0);
        tk = br && ((ins[11] && model_cc == 0) || (ins[10] && model_cc == 1) ||
                    (ins[9] && model_cc == 2));
        off = ins[8] ? int'(ins[8:0]) - 512 : int'(ins[8:0]);
        exp_pc = tk ? ((int'(pc) + off) & 16'hFFFF) : int'(pc);
        check({tag, " R3 flags"}, int'(cc_o), cc_bits(model_cc));
        check({tag, " R4 is_branch"}, int'(is_branch_o), int'(br));
        check({tag, " R5 taken"}, int'(taken_o), int'(tk));
        check({tag, " R7 next_pc"}, int'(next_pc_o), exp_pc);
        @(posedge clk);
        if (wv) model_cc = wd[15] ? 0 : (wd == 16'h0) ? 1 : 2;
    endtask

    initial begin : watchdog
        while (cycles < 100000 && !done) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected 0", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset flags", int'(cc_o), 3'b010);

        // R2: classification of negative, zero, positive, min and max values
        step("R2 neg", 1, 16'h8000, 0, 16'h0, 16'h0);
        step("R2 chk", 0, 16'h0, 0, 16'h0, 16'h0);
        step("R2 zero", 1, 16'h0000, 0, 16'h0, 16'h0);
        step("R2 chk", 0, 16'h0, 0, 16'h0, 16'h0);
        step("R2 pos", 1, 16'h7FFF, 0, 16'h0, 16'h0);
        step("R2 chk", 0, 16'h0, 0, 16'h0, 16'h0);
        step("R2 one", 1, 16'h0001, 0, 16'h0, 16'h0);

        // R5/R6: all masks against all flag states
        for (int f = 0; f < 3; f++) begin
            step("R2 set", 1, (f == 0) ? 16'hFFFB : (f == 1) ? 16'h0 : 16'h0007,
                 0, 16'h0, 16'h0);
            for (int m = 0; m < 8; m++)
                step((m == 0 || m == 7) ? "R6 mask" : "R5 mask", 0, 16'h0, 1,
                     {4'h0, 3'(m), 9'h005}, 16'h1000);
        end

        // R7: offset extremes and wraparound (flags are positive, mask 111)
        step("R7 +255",      0, 16'h0, 1, {4'h0, 3'b111, 9'h0FF}, 16'h3000);
        step("R7 -256",      0, 16'h0, 1, {4'h0, 3'b111, 9'h100}, 16'h3000);
        step("R7 zero off",  0, 16'h0, 1, {4'h0, 3'b111, 9'h000}, 16'h3000);
        step("R7 wrap up",   0, 16'h0, 1, {4'h0, 3'b111, 9'h0FF}, 16'hFF80);
        step("R7 wrap down", 0, 16'h0, 1, {4'h0, 3'b111, 9'h100}, 16'h0010);
        step("R7 not taken", 0, 16'h0, 1, {4'h0, 3'b100, 9'h0FF}, 16'h4444);

        // R4: other opcodes and eval_valid low
        step("R4 opcode", 0, 16'h0, 1, {4'h2, 3'b111, 9'h0FF}, 16'h1234);
        step("R4 opcode", 0, 16'h0, 1, {4'hF, 3'b111, 9'h0FF}, 16'h1234);
        step("R4 no eval", 0, 16'h0, 0, {4'h0, 3'b111, 9'h0FF}, 16'h1234);

        // R8: write and branch together use the old flags (positive here)
        step("R8 same cycle", 1, 16'h9000, 1, {4'h0, 3'b001, 9'h010}, 16'h2000);
        step("R8 next cycle", 0, 16'h0, 1, {4'h0, 3'b001, 9'h010}, 16'h2000);
        step("R8 next cycle", 1, 16'h0, 1, {4'h0, 3'b100, 9'h010}, 16'h2000);

        // Mixed pattern
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a, b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr;
            step("R5 mixed", a[0], (a[3:1] == 0) ? 16'h0 : b, a[4],
                 {(a[5] ? a[9:6] : 4'h0), b[11:0]}, a ^ b);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule